// File: doc/BRIEF.md
# Register Ready-Bit Hazard Scoreboard

This block keeps one pending bit for every architectural register of a multi-stream execution unit. Up to eight instruction streams share a single file of 64 data registers and 32 condition registers. Each stream presents at most one issue request per cycle, naming two source operands and one destination, each with an enable. Data registers and condition registers sit in one index space, so a single array of pending bits covers both kinds.

A request is refused when any enabled operand names a register that is still pending. This one check enforces flow, anti and output dependencies together, because the destination is checked as well as the sources. A refused stream raises its own stall flag and keeps its request up. The other streams are not held back. Among the streams that may issue, one is granted each cycle in round-robin order.

The granted destination is marked pending from the next cycle on. A writeback port clears the pending bit of the register that was written. The whole pending array is visible as an output, so the register file and the functional units can read it.

Top module: `reg_wait_scoreboard`

## Requirements
- R1: While reset is asserted and after it is released, every pending bit reads 0, no stall flag is high, and the round-robin search starts at stream 0.
- R2: Register ids 0 to 63 name data registers and ids 64 to 95 name condition registers. Ids 96 to 127 are never pending, never cause a hazard, and are never marked by an issue.
- R3: A request is granted only if none of its enabled sources and not its enabled destination is pending in the current cycle.
- R4: stall_o[s] is high in the same cycle exactly when stream s has a valid request that names a pending register. It is never high together with grant_o[s].
- R5: At most one stream is granted per cycle, and only a stream that is valid and free of hazards. If any such stream exists, one of them is granted.
- R6: The search for a grant starts at the stream after the most recently granted one and wraps from stream 7 to stream 0. With no grant the start point is kept.
- R7: A granted request whose destination enable is 1 makes that register's pending bit 1 from the next cycle on.
- R8: A writeback with wb_valid_i = 1 makes the pending bit of wb_reg_i 0 from the next cycle on. This happens even when an issue marks a different register in the same cycle.
- R9: When an issue marks a register and a writeback clears the same register in the same cycle, the bit ends up 1.
- R10: An operand whose enable is 0 is not checked for hazards. A destination whose enable is 0 marks nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 8 | Per-stream issue request |
| req_src_a_i | input | 56 | First source id per stream, 7 bits each |
| req_src_a_en_i | input | 8 | First source enable per stream |
| req_src_b_i | input | 56 | Second source id per stream, 7 bits each |
| req_src_b_en_i | input | 8 | Second source enable per stream |
| req_dst_i | input | 56 | Destination id per stream, 7 bits each |
| req_dst_en_i | input | 8 | Destination enable per stream |
| wb_valid_i | input | 1 | Writeback strobe |
| wb_reg_i | input | 7 | Id of the register written back |
| grant_o | output | 8 | One-hot issue grant |
| stall_o | output | 8 | Per-stream hazard stall |
| busy_o | output | 96 | Pending bit per register |

## Verification
Assertions check the following on every cycle: the grant is one-hot or empty, a grant goes only to an eligible stream, an eligible stream is never left without a grant when nothing else is granted, the start stream wins whenever it is eligible, a stall never comes with a grant, and a granted destination was not pending. They also check that an issue marks its register in the following cycle, that a lone writeback clears its register, and that a mark wins over a clear of the same register. Only the bench scenarios can show the following: the exact round-robin order over many cycles, the hazards against the right registers, condition ids and out-of-range ids, disabled operands, and the pending array matching an independent model through long random mixes of issues and writebacks.

// File: rtl/rws_pkg.sv
package rws_pkg;
  localparam int unsigned DEF_STREAMS   = 8;
  localparam int unsigned DEF_DATA_REGS = 64;
  localparam int unsigned DEF_COND_REGS = 32;

  // index width that stays at least one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rws_hazard_check.sv
module rws_hazard_check #(
  parameter int unsigned NREGS = 96,
  parameter int unsigned RW    = 7
) (
  input  logic [NREGS-1:0] busy_i,
  input  logic             valid_i,
  input  logic [RW-1:0]    src_a_i,
  input  logic             src_a_en_i,
  input  logic [RW-1:0]    src_b_i,
  input  logic             src_b_en_i,
  input  logic [RW-1:0]    dst_i,
  input  logic             dst_en_i,
  output logic             stall_o,
  output logic             elig_o
);
  localparam logic [RW:0] LIMIT = NREGS[RW:0];

  function automatic logic pending(input logic [RW-1:0] id,
                                   input logic [NREGS-1:0] b);
    if ({1'b0, id} < LIMIT) return b[id];
    return 1'b0;
  endfunction

  logic hit_a, hit_b, hit_d, hazard;

  always_comb begin
    hit_a   = src_a_en_i & pending(src_a_i, busy_i);
    hit_b   = src_b_en_i & pending(src_b_i, busy_i);
    hit_d   = dst_en_i   & pending(dst_i,   busy_i);
    hazard  = hit_a | hit_b | hit_d;
    stall_o = valid_i & hazard;
    elig_o  = valid_i & ~hazard;
  end
endmodule

// File: rtl/rws_rr_arbiter.sv
module rws_rr_arbiter #(
  parameter int unsigned STREAMS = 8,
  parameter int unsigned SW      = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STREAMS-1:0] elig_i,
  output logic [STREAMS-1:0] grant_o,
  output logic [SW-1:0]      gidx_o,
  output logic               gvalid_o
);
  logic [SW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    grant_o  = '0;
    gidx_o   = '0;
    gvalid_o = 1'b0;
    for (int unsigned k = 0; k < STREAMS; k++) begin
      int unsigned idx;
      idx = (32'(ptr_q) + k) % STREAMS;
      if (!gvalid_o && elig_i[idx]) begin
        gvalid_o     = 1'b1;
        grant_o[idx] = 1'b1;
        gidx_o       = idx[SW-1:0];
      end
    end
  end

  always_comb begin
    int unsigned nxt;
    nxt = 32'(gidx_o) + 1;
    if (nxt >= STREAMS) nxt = 0;
    ptr_en = gvalid_o;
    ptr_d  = nxt[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  // R5
  grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & ~elig_i) == '0);
  // R5
  work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig_i) |-> (|grant_o));
  // R6
  rr_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    elig_i[ptr_q] |-> grant_o[ptr_q]);
endmodule

// File: rtl/rws_wait_table.sv
module rws_wait_table #(
  parameter int unsigned NREGS = 96,
  parameter int unsigned RW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en_i,
  input  logic [RW-1:0]    set_id_i,
  input  logic             clr_en_i,
  input  logic [RW-1:0]    clr_id_i,
  output logic [NREGS-1:0] busy_o
);
  localparam logic [RW:0] LIMIT = NREGS[RW:0];

  logic [NREGS-1:0] busy_q, busy_d;
  logic             set_ok, clr_ok, tbl_en;

  always_comb begin
    set_ok = set_en_i & ({1'b0, set_id_i} < LIMIT);
    clr_ok = clr_en_i & ({1'b0, clr_id_i} < LIMIT);
    tbl_en = set_ok | clr_ok;
    busy_d = busy_q;
    if (clr_ok) busy_d[clr_id_i] = 1'b0;
    if (set_ok) busy_d[set_id_i] = 1'b1;   // mark applied last: it wins
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_q <= '0;
    else if (tbl_en) busy_q <= busy_d;
  end

  assign busy_o = busy_q;

  // R7
  mark_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ok |=> busy_q[$past(set_id_i)]);
  // R8
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ok && !(set_ok && set_id_i == clr_id_i)) |=> !busy_q[$past(clr_id_i)]);
  // R9
  mark_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ok && clr_ok && set_id_i == clr_id_i) |=> busy_q[$past(clr_id_i)]);
endmodule

// File: rtl/reg_wait_scoreboard.sv
module reg_wait_scoreboard
  import rws_pkg::*;
#(
  parameter  int unsigned STREAMS   = DEF_STREAMS,
  parameter  int unsigned DATA_REGS = DEF_DATA_REGS,
  parameter  int unsigned COND_REGS = DEF_COND_REGS,
  localparam int unsigned NREGS     = DATA_REGS + COND_REGS,
  localparam int unsigned RW        = idx_w(NREGS),
  localparam int unsigned SW        = idx_w(STREAMS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [STREAMS-1:0]    req_valid_i,
  input  logic [STREAMS*RW-1:0] req_src_a_i,
  input  logic [STREAMS-1:0]    req_src_a_en_i,
  input  logic [STREAMS*RW-1:0] req_src_b_i,
  input  logic [STREAMS-1:0]    req_src_b_en_i,
  input  logic [STREAMS*RW-1:0] req_dst_i,
  input  logic [STREAMS-1:0]    req_dst_en_i,
  input  logic                  wb_valid_i,
  input  logic [RW-1:0]         wb_reg_i,
  output logic [STREAMS-1:0]    grant_o,
  output logic [STREAMS-1:0]    stall_o,
  output logic [NREGS-1:0]      busy_o
);
  localparam logic [RW:0] LIMIT = NREGS[RW:0];

  logic [STREAMS-1:0] elig;
  logic [SW-1:0]      gidx;
  logic               gvalid;
  logic               set_en;
  logic [RW-1:0]      set_id;

  for (genvar s = 0; s < STREAMS; s++) begin : g_chk
    rws_hazard_check #(.NREGS(NREGS), .RW(RW)) u_chk (
      .busy_i    (busy_o),
      .valid_i   (req_valid_i[s]),
      .src_a_i   (req_src_a_i[s*RW +: RW]),
      .src_a_en_i(req_src_a_en_i[s]),
      .src_b_i   (req_src_b_i[s*RW +: RW]),
      .src_b_en_i(req_src_b_en_i[s]),
      .dst_i     (req_dst_i[s*RW +: RW]),
      .dst_en_i  (req_dst_en_i[s]),
      .stall_o   (stall_o[s]),
      .elig_o    (elig[s])
    );

    // R3
    granted_dst_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o[s] && req_dst_en_i[s] && ({1'b0, req_dst_i[s*RW +: RW]} < LIMIT))
        |-> !busy_o[req_dst_i[s*RW +: RW]]);
  end

  rws_rr_arbiter #(.STREAMS(STREAMS), .SW(SW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig_i  (elig),
    .grant_o (grant_o),
    .gidx_o  (gidx),
    .gvalid_o(gvalid)
  );

  always_comb begin
    set_en = gvalid & req_dst_en_i[gidx];
    set_id = req_dst_i[gidx*RW +: RW];
  end

  rws_wait_table #(.NREGS(NREGS), .RW(RW)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en_i(set_en),
    .set_id_i(set_id),
    .clr_en_i(wb_valid_i),
    .clr_id_i(wb_reg_i),
    .busy_o  (busy_o)
  );

  // R4
  stall_grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o & grant_o) == '0);
endmodule

// File: tb/reg_wait_scoreboard_tb_top.sv
module reg_wait_scoreboard_tb_top;
  localparam int S  = 8;
  localparam int NR = 96;
  localparam int RW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic [S-1:0]    req_valid, a_en, b_en, d_en;
  logic [S*RW-1:0] src_a, src_b, dst;
  logic            wb_valid;
  logic [RW-1:0]   wb_reg;
  logic [S-1:0]    grant, stall;
  logic [NR-1:0]   busy;

  reg_wait_scoreboard dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid),
    .req_src_a_i(src_a), .req_src_a_en_i(a_en),
    .req_src_b_i(src_b), .req_src_b_en_i(b_en),
    .req_dst_i(dst), .req_dst_en_i(d_en),
    .wb_valid_i(wb_valid), .wb_reg_i(wb_reg),
    .grant_o(grant), .stall_o(stall), .busy_o(busy)
  );

  int checks = 0;
  int errors = 0;
  bit m_busy [NR];
  int m_ptr;
  logic [S-1:0] exp_grant, exp_stall;
  int exp_gidx;

  function automatic bit pend(input logic [RW-1:0] id);
    if (int'(id) < NR) return m_busy[id];
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic predict();
    logic [S-1:0] el;
    for (int s = 0; s < S; s++) begin
      bit hz;
      hz = (a_en[s] && pend(src_a[s*RW +: RW])) ||
           (b_en[s] && pend(src_b[s*RW +: RW])) ||
           (d_en[s] && pend(dst[s*RW +: RW]));
      exp_stall[s] = req_valid[s] && hz;
      el[s]        = req_valid[s] && !hz;
    end
    exp_grant = '0;
    exp_gidx  = -1;
    for (int k = 0; k < S; k++) begin
      int i;
      i = (m_ptr + k) % S;
      if (exp_gidx < 0 && el[i]) begin
        exp_gidx     = i;
        exp_grant[i] = 1'b1;
      end
    end
  endtask

  task automatic commit();
    if (wb_valid && int'(wb_reg) < NR) m_busy[wb_reg] = 1'b0;
    if (exp_gidx >= 0) begin
      if (d_en[exp_gidx] && int'(dst[exp_gidx*RW +: RW]) < NR)
        m_busy[dst[exp_gidx*RW +: RW]] = 1'b1;
      m_ptr = (exp_gidx + 1) % S;
    end
  endtask

  task automatic step(input string gtag, input string btag);
    logic [NR-1:0] eb;
    @(negedge clk);
    #2;
    for (int r = 0; r < NR; r++) eb[r] = m_busy[r];
    chk(btag, "busy", 128'(busy), 128'(eb));
    predict();
    chk(gtag, "grant", 128'(grant), 128'(exp_grant));
    chk("R4", "stall", 128'(stall), 128'(exp_stall));
    commit();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    req_valid = '0; a_en = '0; b_en = '0; d_en = '0;
    src_a = '0; src_b = '0; dst = '0;
    wb_valid = 1'b0; wb_reg = '0;
  endtask

  task automatic set_req(input int s, input int a, input bit ae,
                         input int b, input bit be, input int d, input bit de);
    req_valid[s]     = 1'b1;
    src_a[s*RW +: RW] = RW'(a); a_en[s] = ae;
    src_b[s*RW +: RW] = RW'(b); b_en[s] = be;
    dst[s*RW +: RW]   = RW'(d); d_en[s] = de;
  endtask

  function automatic int pick_id();
    int sel;
    sel = int'($urandom % 4);
    if (sel == 0) return int'($urandom % 128);
    if (sel == 1) return 64 + int'($urandom % 4);
    return int'($urandom % 8);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int r = 0; r < NR; r++) m_busy[r] = 1'b0;
    m_ptr = 0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "busy in reset", 128'(busy), 128'(0));
    chk("R1", "stall in reset", 128'(stall), 128'(0));
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    step("R1", "R1");

    // R7: stream 0 marks register 5
    set_req(0, 0, 0, 0, 0, 5, 1);
    step("R7", "R7");
    idle();
    // R3: flow hazard on a source
    set_req(1, 5, 1, 0, 0, 9, 1);
    step("R3", "R7");
    // R3: hazard on the destination
    idle(); set_req(1, 1, 1, 2, 1, 5, 1);
    step("R3", "R3");
    // R10: disabled operand naming a pending register
    idle(); set_req(1, 5, 0, 5, 0, 6, 1);
    step("R10", "R10");
    // R10: disabled destination marks nothing
    idle(); set_req(2, 0, 0, 0, 0, 12, 0);
    step("R10", "R10");
    idle();
    step("R10", "R10");
    // R8: writeback clears, stream waits one cycle then goes
    set_req(1, 5, 1, 0, 0, 0, 0);
    wb_valid = 1'b1; wb_reg = 7'd5;
    step("R8", "R8");
    wb_valid = 1'b0;
    step("R8", "R8");
    // R9: mark and clear of the same register in one cycle
    idle(); set_req(3, 0, 0, 0, 0, 40, 1);
    wb_valid = 1'b1; wb_reg = 7'd40;
    step("R9", "R9");
    idle();
    step("R9", "R9");
    // R8: mark 41 while clearing 40
    set_req(3, 0, 0, 0, 0, 41, 1);
    wb_valid = 1'b1; wb_reg = 7'd40;
    step("R8", "R8");
    idle();
    step("R8", "R8");
    // R2: condition register id and out-of-range ids
    set_req(4, 0, 0, 0, 0, 70, 1);
    step("R2", "R2");
    idle(); set_req(4, 120, 1, 127, 1, 100, 1);
    step("R2", "R2");
    idle(); set_req(5, 70, 1, 0, 0, 0, 0);
    step("R2", "R2");
    idle();
    step("R2", "R2");
    // R6: all streams ready, grants rotate
    for (int s = 0; s < S; s++) set_req(s, 0, 0, 0, 0, 0, 0);
    for (int n = 0; n < 10; n++) step("R6", "R6");
    idle();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      idle();
      for (int s = 0; s < S; s++) begin
        if ($urandom % 3 != 0)
          set_req(s, pick_id(), 1'($urandom), pick_id(), 1'($urandom),
                  pick_id(), 1'($urandom));
      end
      wb_valid = 1'($urandom % 5 < 3);
      wb_reg   = RW'(pick_id());
      step("R5", "R7 R8");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule